// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Condition Flags

This block is the execute stage of a small 16-bit processor core. Each accepted operation takes a source operand and a second operand. The second operand is either a register value or a 4-bit immediate taken from the instruction. The block computes a 16-bit result, a write-back strobe and a set of condition flags: carry, zero, sign and overflow. The flags are held inside the unit, so add-with-carry and subtract-with-carry always see the carry left by the previous flag-setting operation.

An operation is named by a 3-bit family code and a 2-bit mode code. Together they pick one of add, add with carry, subtract, subtract with carry, compare, AND, bit-clear, OR, XOR, and signed or unsigned 8x8 multiply. Every output is registered, so a result appears one clock after its request. The register file and the rest of instruction decode sit outside this unit.

Top module: `alu16_flags`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` and `wr_en` are 0 and all four flags are 0.
- R2: An operation presented with `in_valid` high appears on `result`, `wr_en` and the flags in the next cycle, and `out_valid` is high in that cycle.
- R3: Family 0 is the add group. Mode 1 and mode 3 add the held carry flag as well. The new carry is set when the unsigned 17-bit sum is 0x10000 or more. Overflow is bit 15 of (NOT(a XOR b)) AND (b XOR sum).
- R4: Family 1 modes 0, 1 and 2 subtract. Mode 1 also subtracts the inverse of the held carry. Carry is set when the unsigned difference does not go below zero, so carry means no borrow. Overflow is bit 15 of (a XOR b) AND (a XOR diff).
- R5: Family 1 mode 3 is compare. It always uses `reg_b` and ignores the carry flag. It sets all four flags exactly as a plain subtract does and drives `wr_en` low.
- R6: Family 2 gives a AND b in modes 0 and 2, and a AND NOT b in modes 1 and 3. Family 3 gives a OR b in modes 0 and 2, and a XOR b in modes 1 and 3.
- R7: Families 2, 3 and 4 change only the sign and zero flags. Carry and overflow keep their earlier values.
- R8: Family 4 multiplies the low 8 bits of each operand into a 16-bit product. Modes 0 and 2 treat both bytes as signed. Modes 1 and 3 treat them as unsigned.
- R9: In modes 2 and 3 the second operand is `imm_n` zero-extended to 16 bits, not `reg_b`. Family 1 mode 3 is the one exception.
- R10: After each operation, sign is bit 15 of the computed value and zero is set exactly when all 16 bits of that value are 0. For compare, the computed value is the difference.
- R11: A cycle with `in_valid` low gives `out_valid` low in the next cycle and leaves the flags unchanged. A request with family code 5, 6 or 7 gives `out_valid` high and `wr_en` low, and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op_family | input | 3 | Operation group (0 add, 1 sub, 2 and, 3 or, 4 mul) |
| op_mode | input | 2 | Variant within the group |
| src_a | input | 16 | Source operand |
| reg_b | input | 16 | Register second operand |
| imm_n | input | 4 | Immediate second operand |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | 16 | Computed value |
| wr_en | output | 1 | Destination register should be written |
| flag_c | output | 1 | Carry flag (no-borrow after subtract) |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Every result, write strobe and flag update is due exactly one rising edge after the request that caused it. The bench drives each request on a falling edge and queues the value its reference model expects. The monitor then takes the oldest queued item on the next falling edge, when `out_valid` should be high, so each item is compared half a cycle after the edge that produced it. The reference keeps its own copy of the flags, which lets chained carry operations, compares and flag-preserving logic operations be predicted across a whole run. Idle cycles are checked for a low `out_valid` and unchanged flags in the same way.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [2:0] {
    FAM_ADD = 3'd0,
    FAM_SUB = 3'd1,
    FAM_AND = 3'd2,
    FAM_OR  = 3'd3,
    FAM_MUL = 3'd4
  } fam_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
  } flags_t;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         use_carry,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         v_out
);
  logic [W:0]   ext;
  logic [W-1:0] ovf_vec;

  always_comb begin
    if (!sub) begin
      ext     = {1'b0, a} + {1'b0, b} + (W+1)'(use_carry & cin);
      res     = ext[W-1:0];
      c_out   = ext[W];
      ovf_vec = ~(a ^ b) & (b ^ res);
    end else begin
      ext     = {1'b0, a} - {1'b0, b} - (W+1)'(use_carry & ~cin);
      res     = ext[W-1:0];
      c_out   = ~ext[W];
      ovf_vec = (a ^ b) & (a ^ res);
    end
    v_out = ovf_vec[W-1];
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         or_group,
  input  logic         alt,
  output logic [W-1:0] res
);
  always_comb begin
    if (!or_group) res = alt ? (a & ~b) : (a & b);
    else           res = alt ? (a ^ b)  : (a | b);
  end
endmodule

// File: rtl/alu16_mul.sv
module alu16_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         signed_en,
  output logic [W-1:0] res
);
  localparam int HW = W / 2;

  logic signed [HW:0]     sa;
  logic signed [HW:0]     sb;
  logic signed [2*HW+1:0] prod;

  always_comb begin
    sa   = {signed_en & a[HW-1], a[HW-1:0]};
    sb   = {signed_en & b[HW-1], b[HW-1:0]};
    prod = sa * sb;
    res  = prod[W-1:0];
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int W     = 16,
  parameter int IMM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       op_family,
  input  logic [1:0]       op_mode,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     reg_b,
  input  logic [IMM_W-1:0] imm_n,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             wr_en,
  output logic             flag_c,
  output logic             flag_z,
  output logic             flag_s,
  output logic             flag_v
);
  flags_t       fl_q, fl_d;
  logic [W-1:0] res_d;
  logic         wr_d;
  logic         is_cmp, use_imm;
  logic [W-1:0] opnd_b;
  logic [W-1:0] as_res, lg_res, mu_res;
  logic         as_c, as_v, as_sub, as_carry;

  assign is_cmp   = (op_family == FAM_SUB) && (op_mode == 2'd3);
  assign use_imm  = op_mode[1] && !is_cmp;
  assign opnd_b   = use_imm ? W'(imm_n) : reg_b;
  assign as_sub   = (op_family == FAM_SUB);
  assign as_carry = as_sub ? (op_mode == 2'd1) : op_mode[0];

  alu16_addsub #(.W(W)) u_addsub (
    .a(src_a), .b(opnd_b), .sub(as_sub), .use_carry(as_carry),
    .cin(fl_q.c), .res(as_res), .c_out(as_c), .v_out(as_v)
  );

  alu16_logic #(.W(W)) u_logic (
    .a(src_a), .b(opnd_b), .or_group(op_family == FAM_OR),
    .alt(op_mode[0]), .res(lg_res)
  );

  alu16_mul #(.W(W)) u_mul (
    .a(src_a), .b(opnd_b), .signed_en(~op_mode[0]), .res(mu_res)
  );

  always_comb begin
    fl_d  = fl_q;
    res_d = '0;
    wr_d  = 1'b0;
    case (op_family)
      FAM_ADD, FAM_SUB: begin
        res_d = as_res;
        wr_d  = !is_cmp;
        fl_d  = '{c: as_c, z: (as_res == '0), s: as_res[W-1], v: as_v};
      end
      FAM_AND, FAM_OR: begin
        res_d  = lg_res;
        wr_d   = 1'b1;
        fl_d.z = (lg_res == '0);
        fl_d.s = lg_res[W-1];
      end
      FAM_MUL: begin
        res_d  = mu_res;
        wr_d   = 1'b1;
        fl_d.z = (mu_res == '0);
        fl_d.s = mu_res[W-1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      fl_q      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wr_en  <= wr_d;
        result <= res_d;
        fl_q   <= fl_d;
      end else begin
        wr_en  <= 1'b0;
      end
    end
  end

  assign flag_c = fl_q.c;
  assign flag_z = fl_q.z;
  assign flag_s = fl_q.s;
  assign flag_v = fl_q.v;

  // R2: a request is answered on the following cycle
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R5: compare never asks for a register write
  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_cmp) |=> (out_valid && !wr_en));

  // R7: logic and multiply keep carry and overflow
  p_keep_cv_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_family == FAM_AND || op_family == FAM_OR || op_family == FAM_MUL))
      |=> ($stable(flag_c) && $stable(flag_v)));

  // R10: zero and sign agree with a written result
  p_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wr_en) |-> (flag_z == (result == '0)));
  p_sign_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wr_en) |-> (flag_s == result[W-1]));

  // R11: idle cycles leave the flags alone
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable({flag_c, flag_z, flag_s, flag_v})));
endmodule

// File: tb/test_alu16_flags.sv
module test_alu16_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_family = '0;
  logic [1:0]  op_mode = '0;
  logic [15:0] src_a = '0;
  logic [15:0] reg_b = '0;
  logic [3:0]  imm_n = '0;
  logic        out_valid, wr_en, flag_c, flag_z, flag_s, flag_v;
  logic [15:0] result;

  always #10 clk = ~clk;

  alu16_flags i_alu16_flags (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_family(op_family),
    .op_mode(op_mode), .src_a(src_a), .reg_b(reg_b), .imm_n(imm_n),
    .out_valid(out_valid), .result(result), .wr_en(wr_en),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v)
  );

  typedef struct {
    logic [15:0] res;
    logic        wr;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          fails  = 0;
  logic [3:0]  m_fl = 4'b0000; // {c,z,s,v}

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  function automatic string fam_tag(input int f, input int m);
    case (f)
      0: return "R3";
      1: return (m == 3) ? "R5" : "R4";
      2, 3: return "R6";
      4: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic drive(input int f, input int m, input logic [15:0] a,
                       input logic [15:0] b, input logic [3:0] n);
    exp_t        e;
    logic [15:0] bo, r;
    int          s;
    logic        c, v;
    bit          imm;
    imm = (m >= 2) && !(f == 1 && m == 3);
    bo  = imm ? {12'h000, n} : b;
    e.wr = 1'b1;
    e.fl = m_fl;
    e.tag = fam_tag(f, m);
    if (imm && f <= 4) e.tag = {e.tag, "/R9"};
    r = 16'h0000;
    case (f)
      0: begin
        s = int'(a) + int'(bo) + ((m % 2 == 1) ? int'(m_fl[3]) : 0);
        r = s[15:0];
        c = (s >= 65536);
        v = ((~(a ^ bo)) & (bo ^ r) & 16'h8000) != 16'h0000;
        e.fl = {c, r == 16'h0000, r[15], v};
      end
      1: begin
        s = int'(a) - int'(bo) - ((m == 1) ? int'(!m_fl[3]) : 0);
        r = s[15:0];
        c = (s >= 0);
        v = ((a ^ bo) & (a ^ r) & 16'h8000) != 16'h0000;
        e.fl = {c, r == 16'h0000, r[15], v};
        e.wr = (m != 3);
      end
      2: r = (m % 2 == 1) ? (a & ~bo) : (a & bo);
      3: r = (m % 2 == 1) ? (a ^ bo) : (a | bo);
      4: begin
        if (m % 2 == 0) s = int'($signed(a[7:0])) * int'($signed(bo[7:0]));
        else            s = int'(a[7:0]) * int'(bo[7:0]);
        r = s[15:0];
      end
      default: e.wr = 1'b0;
    endcase
    if (f >= 2 && f <= 4) begin
      e.fl[2] = (r == 16'h0000);
      e.fl[1] = r[15];
    end
    e.res = r;
    m_fl  = e.fl;
    sb_q.push_back(e);
    @(negedge clk);
    in_valid  = 1'b1;
    op_family = 3'(f);
    op_mode   = 2'(m);
    src_a     = a;
    reg_b     = b;
    imm_n     = n;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops the item queued one falling edge earlier
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2", "out_valid high with nothing expected");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(wr_en == e.wr && (!e.wr || result == e.res) &&
              {flag_c, flag_z, flag_s, flag_v} == e.fl, e.tag,
              $sformatf("res %h wr %b czsv %b, expected res %h wr %b czsv %b",
                        result, wr_en, {flag_c, flag_z, flag_s, flag_v},
                        e.res, e.wr, e.fl));
      end
    end
  end

  initial begin
    #2000000;
    check(1'b0, "WATCHDOG", "run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] edge_v [7];
    edge_v = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h00FF, 16'h0080};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0 && wr_en == 1'b0 &&
          {flag_c, flag_z, flag_s, flag_v} == 4'b0000, "R1",
          $sformatf("ov %b wr %b czsv %b, expected 0 0 0000", out_valid, wr_en,
                    {flag_c, flag_z, flag_s, flag_v}));
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && {flag_c, flag_z, flag_s, flag_v} == 4'b0000, "R1",
          $sformatf("after reset ov %b czsv %b, expected 0 0000", out_valid,
                    {flag_c, flag_z, flag_s, flag_v}));

    // directed corner cases
    drive(0, 0, 16'hFFFF, 16'h0001, 4'h0);   // R3 carry out, zero
    drive(0, 0, 16'h7FFF, 16'h0001, 4'h0);   // R3 overflow
    drive(0, 0, 16'hFFFF, 16'hFFFF, 4'h0);   // carry set for next
    drive(0, 1, 16'h0001, 16'h0001, 4'h0);   // R3 adc with carry -> 3
    drive(1, 0, 16'h0000, 16'h0001, 4'h0);   // R4 borrow, carry clear
    drive(1, 1, 16'h0005, 16'h0002, 4'h0);   // R4 sbc with borrow -> 2
    drive(1, 0, 16'h8000, 16'h0001, 4'h0);   // R4 overflow
    drive(1, 3, 16'h1234, 16'h1234, 4'hF);   // R5 compare equal, no write
    drive(2, 0, 16'hF0F0, 16'h0F0F, 4'h0);   // R6/R7 carry kept
    drive(3, 1, 16'hAAAA, 16'hAAAA, 4'h0);   // R6 xor -> zero
    drive(4, 0, 16'h00FF, 16'h0080, 4'h0);   // R8 signed -1*-128 = 0x0080
    drive(4, 1, 16'h00FF, 16'h0080, 4'h0);   // R8 unsigned 255*128 = 0x7F80
    drive(4, 2, 16'h0080, 16'hFFFF, 4'hF);   // R9 signed by imm 15
    drive(0, 2, 16'h0010, 16'hFFFF, 4'h3);   // R9 add imm -> 0x13
    drive(5, 0, 16'h0000, 16'h0000, 4'h0);   // R11 invalid family
    idle(3);
    check(out_valid == 1'b0 && {flag_c, flag_z, flag_s, flag_v} == m_fl, "R11",
          $sformatf("idle ov %b czsv %b, expected 0 %b", out_valid,
                    {flag_c, flag_z, flag_s, flag_v}, m_fl));

    // boundary grid for add and subtract groups
    foreach (edge_v[i]) foreach (edge_v[j])
      for (int m = 0; m < 4; m++) begin
        drive(0, m, edge_v[i], edge_v[j], edge_v[j][3:0]);
        drive(1, m, edge_v[i], edge_v[j], edge_v[j][3:0]);
      end

    // random operands over every family and mode, with idle gaps
    for (int k = 0; k < 30; k++)
      for (int f = 0; f < 6; f++)
        for (int m = 0; m < 4; m++) begin
          drive(f, m, 16'($urandom), 16'($urandom), 4'($urandom));
          if (k % 7 == 3) idle(1);
        end

    idle(3);
    check(sb_q.size() == 0, "R2",
          $sformatf("%0d results missing, expected 0", sb_q.size()));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule